// File: doc/BRIEF.md
# Package Low-Power State Sequencer

This block decides when a multi-core processor package may leave its running state and enter a low-power halt. It combines one halt flag from each logical core with the wake sources, a stop-clock request and a management-mode return. From these it moves the package through running (Normal), plain halt, a stop-clock substate of halt, and a deep halt in which the core clock ratio and the supply voltage are both lowered.

The deep halt uses two request/acknowledge handshakes: one to the core clock-ratio generator and one to the voltage regulator. On entry the ratio drops before the voltage. On exit the voltage is raised before the ratio returns. Each step waits for its acknowledge. A step that waits longer than a programmable count raises a sticky error flag. If a wake event arrives before the deep halt is reached, the sequencer completes the step in flight and then undoes only the steps already taken, voltage first. Snoop requests are answered in every state except the stop-clock substate.

Top module: `lp_state_seq`

## Requirements
- R1: While `rst` is high, at each clock edge the block returns to Normal. In that state `pkg_state` is 0, `ratio_low`, `vid_low`, `ratio_req`, `vid_req`, `step_err` and `snoop_ack` are 0, and `snoop_en` is 1.
- R2: While any bit of `core_halt` is 0, the package stays in Normal (`pkg_state` 0).
- R3: When every `core_halt` bit is 1 in Normal and no wake event is present, the next state depends on `enh_en` in that same cycle. If `enh_en` is 0, the next state is plain halt (`pkg_state` 1). If `enh_en` is 1, the next state is ratio-lowering entry (`pkg_state` 3).
- R4: A pulse on any single wake source (`smi_evt`, `binit_evt`, `init_evt`, any `lint_evt` bit, `bus_irq_evt`) has two effects. In plain halt, it returns the package to Normal on the next cycle. In deep halt (`pkg_state` 5), it starts the exit sequence (`pkg_state` 6) on the next cycle.
- R5: In plain halt, `stopclk_req` high moves the package to the stop-clock substate (`pkg_state` 2) on the next cycle. Wake events have no effect there. Once `stopclk_req` is low, the package returns to plain halt (`pkg_state` 1), not to Normal.
- R6: Entry order is as follows. `ratio_low` and `ratio_req` rise together. `vid_low` rises only after the ratio acknowledge (state 4). Deep halt (state 5) is reached after the voltage acknowledge, with `ratio_low` and `vid_low` at 1 and both requests at 0.
- R7: Exit order is as follows. `vid_low` falls first while `ratio_low` stays 1 (state 6). `ratio_low` falls only after the voltage acknowledge (state 7). Normal follows the ratio acknowledge.
- R8: A request output stays high until its acknowledge is sampled, and no later step starts before then.
- R9: With `step_limit` nonzero, a request left without acknowledge for `step_limit` cycles sets `step_err`. The flag then stays 1 until reset. A `step_limit` of 0 disables the timeout.
- R10: A wake event during ratio entry (state 3) has this effect: after the ratio acknowledge, only the ratio is restored (state 7), then Normal follows, and `vid_low` never rises. A wake event during voltage entry (state 4) has this effect: after the voltage acknowledge, the full exit runs (states 6 then 7) and deep halt is skipped.
- R11: `snoop_en` is 1 in every state except stop-clock, where it is 0. `snoop_ack` follows `snoop_req` one cycle later, except when the package is then in stop-clock.
- R12: In Normal, a `smm_done` pulse moves the package to plain halt when `smm_resume_halt` is 1. When `smm_resume_halt` is 0, the package stays in Normal.
- R13: Reset asserted in the middle of an entry sequence restores the R1 values at the next edge, including clearing `step_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halt | input | N_CORES | Per-core halt flag |
| smi_evt | input | 1 | Management interrupt wake |
| binit_evt | input | 1 | Bus-init wake |
| init_evt | input | 1 | Init wake |
| lint_evt | input | N_LINT | Local interrupt lines wake |
| bus_irq_evt | input | 1 | Interrupt message from the bus |
| stopclk_req | input | 1 | Stop-clock request |
| enh_en | input | 1 | Select deep halt on entry |
| smm_done | input | 1 | Management handler completed |
| smm_resume_halt | input | 1 | Resume target: 1 halt, 0 Normal |
| snoop_req | input | 1 | Incoming snoop request |
| ratio_ack | input | 1 | Ratio generator acknowledge |
| vid_ack | input | 1 | Voltage regulator acknowledge |
| step_limit | input | TO_W | Handshake timeout count, 0 disables |
| pkg_state | output | 3 | Current state code |
| ratio_low | output | 1 | Core ratio select, 1 = low ratio |
| ratio_req | output | 1 | Ratio change request |
| vid_low | output | 1 | Voltage select, 1 = low voltage |
| vid_req | output | 1 | Voltage change request |
| step_err | output | 1 | Sticky handshake timeout flag |
| snoop_en | output | 1 | Snoop servicing enabled |
| snoop_ack | output | 1 | Snoop request answered |

## Verification
Assertions check on every cycle:
- the ratio/voltage ordering on both edges of the deep-halt sequence;
- the request hold rule and the sticky error;
- immediate wake from plain halt;
- the return from stop-clock to halt;
- that snoops stay enabled in both halts.

Only the bench scenarios can show some other behaviours. These are the abort paths and the set of states they visit, the exact cycle at which the timeout fires, that wake pulses are ignored in stop-clock, the management-mode resume target, and reset in the middle of a sequence. Random handshake delays and randomly chosen wake sources exercise the full round trip many times.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL     = 3'd0,
    ST_HALT       = 3'd1,
    ST_STOPCLK    = 3'd2,
    ST_ENT_RATIO  = 3'd3,
    ST_ENT_VID    = 3'd4,
    ST_EHALT      = 3'd5,
    ST_EXIT_VID   = 3'd6,
    ST_EXIT_RATIO = 3'd7
  } lp_state_e;

  localparam int unsigned STEP_RATIO = 0;
  localparam int unsigned STEP_VID   = 1;
  localparam int unsigned N_STEPS    = 2;

  function automatic logic in_entry(lp_state_e s);
    return (s == ST_ENT_RATIO) || (s == ST_ENT_VID);
  endfunction
endpackage

// File: rtl/lp_wake_merge.sv
module lp_wake_merge #(
  parameter int unsigned N_CORES = 2,
  parameter int unsigned N_LINT  = 2
) (
  input  logic [N_CORES-1:0] core_halt,
  input  logic               smi_evt,
  input  logic               binit_evt,
  input  logic               init_evt,
  input  logic [N_LINT-1:0]  lint_evt,
  input  logic               bus_irq_evt,
  output logic               all_halt,
  output logic               brk_any
);
  // Package may only idle once every logical core has flagged halt.
  always_comb begin
    all_halt = 1'b1;
    for (int i = 0; i < N_CORES; i++) all_halt = all_halt & core_halt[i];
  end

  always_comb begin
    brk_any = smi_evt | binit_evt | init_evt | bus_irq_evt;
    for (int j = 0; j < N_LINT; j++) brk_any = brk_any | lint_evt[j];
  end
endmodule

// File: rtl/lp_step_hs.sv
module lp_step_hs #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            tgt,
  input  logic            ack,
  input  logic [TO_W-1:0] limit,
  output logic            sel,
  output logic            req,
  output logic            done,
  output logic            err
);
  logic [TO_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= 1'b0;
      req      <= 1'b0;
      wait_cnt <= '0;
      err      <= 1'b0;
    end else if (start) begin
      sel      <= tgt;
      req      <= 1'b1;
      wait_cnt <= '0;
    end else if (req && ack) begin
      req <= 1'b0;
    end else if (req) begin
      if (wait_cnt != '1) wait_cnt <= wait_cnt + 1'b1;
      if ((limit != '0) && (wait_cnt >= limit - 1'b1)) err <= 1'b1;
    end
  end

  assign done = req & ack;

  // R8: an open request is never withdrawn before its acknowledge
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !start) |=> req);
  // R8: a new step is only launched on an idle or completing handshake
  p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> (!req || ack));
  // R9: timeout flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/lp_state_seq.sv
module lp_state_seq
  import lp_seq_pkg::*;
#(
  parameter int unsigned N_CORES = 2,
  parameter int unsigned N_LINT  = 2,
  parameter int unsigned TO_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] core_halt,
  input  logic               smi_evt,
  input  logic               binit_evt,
  input  logic               init_evt,
  input  logic [N_LINT-1:0]  lint_evt,
  input  logic               bus_irq_evt,
  input  logic               stopclk_req,
  input  logic               enh_en,
  input  logic               smm_done,
  input  logic               smm_resume_halt,
  input  logic               snoop_req,
  input  logic               ratio_ack,
  input  logic               vid_ack,
  input  logic [TO_W-1:0]    step_limit,
  output logic [2:0]         pkg_state,
  output logic               ratio_low,
  output logic               ratio_req,
  output logic               vid_low,
  output logic               vid_req,
  output logic               step_err,
  output logic               snoop_en,
  output logic               snoop_ack
);
  lp_state_e state, nxt;
  logic all_halt, brk_any, brk_pend;
  logic [N_STEPS-1:0] st_go, st_tgt, st_ack, st_sel, st_req, st_done, st_err;

  lp_wake_merge #(.N_CORES(N_CORES), .N_LINT(N_LINT)) u_merge (
    .core_halt  (core_halt),
    .smi_evt    (smi_evt),
    .binit_evt  (binit_evt),
    .init_evt   (init_evt),
    .lint_evt   (lint_evt),
    .bus_irq_evt(bus_irq_evt),
    .all_halt   (all_halt),
    .brk_any    (brk_any)
  );

  assign st_ack[STEP_RATIO] = ratio_ack;
  assign st_ack[STEP_VID]   = vid_ack;

  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    lp_step_hs #(.TO_W(TO_W)) u_step (
      .clk  (clk),
      .rst  (rst),
      .start(st_go[g]),
      .tgt  (st_tgt[g]),
      .ack  (st_ack[g]),
      .limit(step_limit),
      .sel  (st_sel[g]),
      .req  (st_req[g]),
      .done (st_done[g]),
      .err  (st_err[g])
    );
  end

  // Next-state and step launches. Ratio goes down first, voltage comes up first.
  always_comb begin
    nxt    = state;
    st_go  = '0;
    st_tgt = '0;
    case (state)
      ST_NORMAL: begin
        if (brk_any) begin
          nxt = ST_NORMAL;
        end else if (all_halt) begin
          if (enh_en) begin
            nxt = ST_ENT_RATIO;
            st_go[STEP_RATIO]  = 1'b1;
            st_tgt[STEP_RATIO] = 1'b1;
          end else begin
            nxt = ST_HALT;
          end
        end else if (smm_done && smm_resume_halt) begin
          nxt = ST_HALT;
        end
      end
      ST_HALT: begin
        if (brk_any)          nxt = ST_NORMAL;
        else if (stopclk_req) nxt = ST_STOPCLK;
      end
      ST_STOPCLK: begin
        if (!stopclk_req) nxt = ST_HALT;
      end
      ST_ENT_RATIO: begin
        if (st_done[STEP_RATIO]) begin
          if (brk_pend || brk_any) begin
            nxt = ST_EXIT_RATIO;
            st_go[STEP_RATIO] = 1'b1;
          end else begin
            nxt = ST_ENT_VID;
            st_go[STEP_VID]  = 1'b1;
            st_tgt[STEP_VID] = 1'b1;
          end
        end
      end
      ST_ENT_VID: begin
        if (st_done[STEP_VID]) begin
          if (brk_pend || brk_any) begin
            nxt = ST_EXIT_VID;
            st_go[STEP_VID] = 1'b1;
          end else begin
            nxt = ST_EHALT;
          end
        end
      end
      ST_EHALT: begin
        if (brk_any) begin
          nxt = ST_EXIT_VID;
          st_go[STEP_VID] = 1'b1;
        end
      end
      ST_EXIT_VID: begin
        if (st_done[STEP_VID]) begin
          nxt = ST_EXIT_RATIO;
          st_go[STEP_RATIO] = 1'b1;
        end
      end
      ST_EXIT_RATIO: begin
        if (st_done[STEP_RATIO]) nxt = ST_NORMAL;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_NORMAL;
      brk_pend  <= 1'b0;
      snoop_en  <= 1'b1;
      snoop_ack <= 1'b0;
    end else begin
      state     <= nxt;
      brk_pend  <= in_entry(state) && in_entry(nxt) && (brk_pend || brk_any);
      snoop_en  <= (nxt != ST_STOPCLK);
      snoop_ack <= snoop_req && (nxt != ST_STOPCLK);
    end
  end

  assign pkg_state = state;
  assign ratio_low = st_sel[STEP_RATIO];
  assign ratio_req = st_req[STEP_RATIO];
  assign vid_low   = st_sel[STEP_VID];
  assign vid_req   = st_req[STEP_VID];
  assign step_err  = |st_err;

  // R6: voltage is lowered only when the ratio is already low
  p_vid_after_ratio_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(vid_low) |-> ratio_low);
  // R6: deep halt holds both low operating points with no open request
  p_ehalt_levels_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EHALT) |-> (ratio_low && vid_low && !ratio_req && !vid_req));
  // R7: ratio is restored only after the voltage is back up
  p_ratio_after_vid_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ratio_low) |-> !vid_low);
  // R2: no halt entry while some core still runs
  p_stay_normal_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORMAL && !all_halt && !(smm_done && smm_resume_halt))
      |=> (state != ST_HALT && state != ST_ENT_RATIO));
  // R4: wake from plain halt is immediate
  p_wake_halt_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && brk_any) |=> (state == ST_NORMAL));
  // R5: leaving stop-clock lands in halt
  p_stopclk_back_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOPCLK && !stopclk_req) |=> (state == ST_HALT));
  // R11: snoops serviced in both halt flavours
  p_snoop_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT || state == ST_EHALT) |-> snoop_en);
endmodule

// File: tb/lp_state_seq_tb.sv
module lp_state_seq_tb;
  localparam int NC = 2;
  localparam int NL = 2;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [NC-1:0] core_halt;
  logic smi_evt, binit_evt, init_evt, bus_irq_evt;
  logic [NL-1:0] lint_evt;
  logic stopclk_req, enh_en, smm_done, smm_resume_halt, snoop_req;
  logic ratio_ack, vid_ack;
  logic [TW-1:0] step_limit;
  logic [2:0] pkg_state;
  logic ratio_low, ratio_req, vid_low, vid_req, step_err, snoop_en, snoop_ack;

  int checks = 0;
  int errors = 0;
  int rdelay = 1, vdelay = 1, rcnt = 0, vcnt = 0;
  bit resp_off = 1'b0;
  bit prev_rl = 1'b0, prev_vl = 1'b0;
  int vmask = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lp_state_seq #(.N_CORES(NC), .N_LINT(NL), .TO_W(TW)) u_dut (
    .clk(clk), .rst(rst), .core_halt(core_halt), .smi_evt(smi_evt),
    .binit_evt(binit_evt), .init_evt(init_evt), .lint_evt(lint_evt),
    .bus_irq_evt(bus_irq_evt), .stopclk_req(stopclk_req), .enh_en(enh_en),
    .smm_done(smm_done), .smm_resume_halt(smm_resume_halt),
    .snoop_req(snoop_req), .ratio_ack(ratio_ack), .vid_ack(vid_ack),
    .step_limit(step_limit), .pkg_state(pkg_state), .ratio_low(ratio_low),
    .ratio_req(ratio_req), .vid_low(vid_low), .vid_req(vid_req),
    .step_err(step_err), .snoop_en(snoop_en), .snoop_ack(snoop_ack)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  // External ratio generator and regulator models: one-cycle acknowledge after a delay.
  always @(negedge clk) begin
    if (ratio_ack) ratio_ack = 1'b0;
    else if (ratio_req && !resp_off) begin
      if (rcnt >= rdelay) begin ratio_ack = 1'b1; rcnt = 0; end
      else rcnt++;
    end else rcnt = 0;
    if (vid_ack) vid_ack = 1'b0;
    else if (vid_req) begin
      if (vcnt >= vdelay) begin vid_ack = 1'b1; vcnt = 0; end
      else vcnt++;
    end else vcnt = 0;
  end

  // Ordering monitor for R6 / R7 and a record of visited states.
  always @(negedge clk) begin
    if (!rst) begin
      if (vid_low && !prev_vl) chk(ratio_low == 1'b1, "R6 vid lowered before ratio", ratio_low, 1);
      if (!ratio_low && prev_rl) chk(vid_low == 1'b0, "R7 ratio restored before vid", vid_low, 0);
    end
    prev_rl = ratio_low;
    prev_vl = vid_low;
    vmask |= (1 << pkg_state);
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_st(input int code, input int maxc, input string rq);
    int n = 0;
    while (pkg_state != code && n < maxc) begin tick(); n++; end
    chk(pkg_state == code, rq, pkg_state, code);
  endtask

  task automatic pulse_brk(input int k);
    case (k)
      0: smi_evt = 1'b1;
      1: binit_evt = 1'b1;
      2: init_evt = 1'b1;
      3: lint_evt[0] = 1'b1;
      4: lint_evt[1] = 1'b1;
      default: bus_irq_evt = 1'b1;
    endcase
    tick();
    smi_evt = 0; binit_evt = 0; init_evt = 0; lint_evt = '0; bus_irq_evt = 0;
  endtask

  task automatic check_reset_vals(input string rq);
    chk(pkg_state == 0, rq, pkg_state, 0);
    chk({ratio_low, vid_low, ratio_req, vid_req} == 4'b0, rq, {ratio_low, vid_low, ratio_req, vid_req}, 0);
    chk(step_err == 0, rq, step_err, 0);
    chk(snoop_en == 1 && snoop_ack == 0, rq, {snoop_en, snoop_ack}, 2);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1; core_halt = '0; smi_evt = 0; binit_evt = 0; init_evt = 0;
    lint_evt = '0; bus_irq_evt = 0; stopclk_req = 0; enh_en = 0;
    smm_done = 0; smm_resume_halt = 0; snoop_req = 0; ratio_ack = 0;
    vid_ack = 0; step_limit = 8'd20;
    repeat (3) tick();
    check_reset_vals("R1 reset state");
    rst = 0;
    tick();

    // R2: partial halt patterns keep Normal
    for (int i = 0; i < 6; i++) begin
      core_halt = NC'($urandom % ((1 << NC) - 1));
      tick();
      chk(pkg_state == 0, "R2 partial halt stays Normal", pkg_state, 0);
    end

    // R3 plain halt, R11 snoop in halt
    core_halt = '1; enh_en = 0; snoop_req = 1;
    tick();
    chk(pkg_state == 1, "R3 plain halt entry", pkg_state, 1);
    tick();
    chk(snoop_en == 1 && snoop_ack == 1, "R11 snoop in halt", {snoop_en, snoop_ack}, 3);

    // R5 stop-clock substate
    stopclk_req = 1;
    tick();
    chk(pkg_state == 2, "R5 stop-clock entry", pkg_state, 2);
    chk(snoop_en == 0 && snoop_ack == 0, "R11 no snoop in stop-clock", {snoop_en, snoop_ack}, 0);
    pulse_brk(2);
    chk(pkg_state == 2, "R5 wake ignored in stop-clock", pkg_state, 2);
    stopclk_req = 0;
    tick();
    chk(pkg_state == 1, "R5 return to halt", pkg_state, 1);
    snoop_req = 0;

    // R4 wake from plain halt
    core_halt = '0;
    pulse_brk(4);
    chk(pkg_state == 0, "R4 wake from halt", pkg_state, 0);

    // R12 management resume target
    smm_done = 1; smm_resume_halt = 0;
    tick();
    chk(pkg_state == 0, "R12 resume to Normal", pkg_state, 0);
    smm_resume_halt = 1;
    tick();
    chk(pkg_state == 1, "R12 resume to halt", pkg_state, 1);
    smm_done = 0; smm_resume_halt = 0;
    pulse_brk(0);
    chk(pkg_state == 0, "R4 wake smi", pkg_state, 0);

    // R3/R6 deep halt entry
    rdelay = 3; vdelay = 2;
    core_halt = '1; enh_en = 1;
    tick();
    chk(pkg_state == 3, "R3 deep entry", pkg_state, 3);
    chk(ratio_low == 1 && ratio_req == 1 && vid_low == 0, "R6 ratio first", {ratio_low, ratio_req, vid_low}, 6);
    enh_en = 0;
    wait_st(4, 20, "R6 voltage step");
    chk(ratio_req == 0 && vid_req == 1, "R8 ratio closed before vid", {ratio_req, vid_req}, 1);
    wait_st(5, 20, "R6 deep halt reached");
    chk(ratio_low && vid_low && !ratio_req && !vid_req, "R6 deep halt levels", {ratio_low, vid_low}, 3);
    chk(snoop_en == 1, "R11 snoop in deep halt", snoop_en, 1);
    chk(step_err == 0, "R9 no timeout with prompt ack", step_err, 0);

    // R4/R7 exit
    core_halt = '0;
    pulse_brk(5);
    chk(pkg_state == 6, "R4 exit starts", pkg_state, 6);
    chk(vid_low == 0 && ratio_low == 1, "R7 voltage first", {vid_low, ratio_low}, 1);
    wait_st(7, 20, "R7 ratio step");
    wait_st(0, 20, "R7 back to Normal");
    chk(ratio_low == 0 && vid_low == 0, "R7 levels restored", {ratio_low, vid_low}, 0);

    // R10 abort during ratio entry
    rdelay = 4; vdelay = 4;
    core_halt = '1; enh_en = 1;
    tick();
    vmask = 0;
    core_halt = '0; enh_en = 0;
    pulse_brk(3);
    wait_st(0, 40, "R10 abort ratio ends Normal");
    chk((vmask & 8'h70) == 0 && (vmask & 8'h80) != 0, "R10 abort ratio path", vmask, 8'h80);
    chk(vid_low == 0 && ratio_low == 0, "R10 levels after abort", {vid_low, ratio_low}, 0);

    // R10 abort during voltage entry
    core_halt = '1; enh_en = 1;
    tick();
    enh_en = 0;
    wait_st(4, 20, "R10 reach voltage step");
    vmask = 0;
    core_halt = '0;
    pulse_brk(1);
    wait_st(0, 40, "R10 abort vid ends Normal");
    chk((vmask & 8'h20) == 0 && (vmask & 8'hC0) == 8'hC0, "R10 abort vid path", vmask, 8'hC0);

    // R9 timeout and stickiness, R8 request hold
    step_limit = 8'd6; resp_off = 1;
    core_halt = '1; enh_en = 1;
    tick();
    enh_en = 0;
    repeat (3) tick();
    chk(step_err == 0, "R9 no error before limit", step_err, 0);
    repeat (7) tick();
    chk(step_err == 1, "R9 timeout flagged", step_err, 1);
    chk(pkg_state == 3 && ratio_req == 1, "R8 waits for ack", {pkg_state, ratio_req}, 7);
    resp_off = 0;
    wait_st(5, 20, "R8 proceeds after late ack");
    core_halt = '0;
    pulse_brk(0);
    wait_st(0, 40, "R7 exit after timeout");
    chk(step_err == 1, "R9 error sticky", step_err, 1);
    step_limit = 8'd20;

    // R13 reset mid-sequence
    core_halt = '1; enh_en = 1;
    tick();
    wait_st(4, 20, "R13 reach voltage step");
    core_halt = '0; enh_en = 0; rst = 1;
    tick();
    check_reset_vals("R13 reset mid-sequence");
    rst = 0;
    tick();

    // Random round trips
    for (int i = 0; i < 20; i++) begin
      int k;
      bit enh;
      rdelay = $urandom % 5; vdelay = $urandom % 5;
      enh = 1'($urandom % 2); k = $urandom % 6;
      core_halt = '1; enh_en = enh;
      tick();
      enh_en = 0;
      if (enh) wait_st(5, 30, "R6 random deep entry");
      else chk(pkg_state == 1, "R3 random plain entry", pkg_state, 1);
      core_halt = '0;
      pulse_brk(k);
      wait_st(0, 30, "R4 random wake to Normal");
      chk(ratio_low == 0 && vid_low == 0, "R7 random levels restored", {ratio_low, vid_low}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule